// File: doc/BRIEF.md
# Shared Majority-Vote Line Filter for Many Serial Inputs

This block cleans up to sixteen independent asynchronous serial lines with a single two-of-three voting datapath instead of sixteen copies. A free-running channel counter gives each line one clock slot in turn. Every raw line first passes through its own synchronizing flip-flop. The line of the current slot is then selected and registered. A small per-channel memory holds the recent samples of each line and the last voted level.

A line's history advances only when the caller raises `sample_en` during that line's slot. `sample_en` is normally the 16x oversampling strobe of that channel. Samples are kept inverted in the memory, so a memory cleared to zero reads as an idle (mark) line. After reset, no channel can present a false start bit.

Downstream receive logic reads `ch_out` and `filt_out` together. They describe the same channel, one clock after that channel's slot.

Top module: `mvf_scan_filter`

## Requirements
- R1: The channel counter is 0 in reset. It steps by one every clock and wraps from NUM_CH-1 to 0, so every channel gets exactly one slot per NUM_CH clocks.
- R2: Each bit of `rx_in` passes through one synchronizing register, reset to 1. A sample taken in the slot that follows clock edge k uses the line level present at edge k-1.
- R3: If `sample_en` is low during a channel's slot, that channel's sample register and history are left unchanged. Its `filt_out` at later slots does not move, however its line changes.
- R4: Each channel holds a 4-bit entry. Bits [2:0] are its three newest samples, bit 0 the newest. Bit 3 is the vote of those three. An enabled slot shifts the new sample in at bit 0.
- R5: The vote is two-of-three. The patterns 000, 001, 010 and 100 give 0. The patterns 011, 101, 110 and 111 give 1.
- R6: The history is stored inverted and cleared to zero in reset. After reset, `filt_out` is 1 (mark) for every channel.
- R7: `ch_out` in the cycle after a slot equals that slot's channel. In the same cycle, `filt_out` is that channel's vote, including the sample just taken when the slot was enabled.
- R8: On a line that has been idle high, a single low sample between high samples never drives `filt_out` low.
- R9: A level held for two consecutive enabled samples makes `filt_out` follow it, at the second sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | NUM_CH | Raw asynchronous serial lines, high is idle |
| sample_en | input | 1 | Sample strobe for the channel of the current slot |
| ch_out | output | CH_W | Registered channel code of the previous slot |
| filt_out | output | 1 | Filtered level of channel `ch_out`, high is mark |

## Verification
A change on `rx_in` reaches the synchronizer at the next edge. It is first used by a slot whose edge comes one clock later. The `ch_out`/`filt_out` pair for a slot appears one clock after that slot's edge, and the updated history is used at the same channel's next slot.

The bench drives inputs on the falling edge. At each rising edge, a scoreboard model built from the requirements queues the expected pair for the cycle that follows. A monitor pops and compares that pair at the next falling edge. Directed sample sequences check the vote table, the single-glitch rejection and the two-sample turnover in the exact cycle where the pair appears.

// File: rtl/mvf_pkg.sv
package mvf_pkg;
    // width of one history entry: three samples plus the voted bit
    localparam int unsigned HIST_W = 4;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction
endpackage

// File: rtl/mvf_sync.sv
module mvf_sync #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = raw_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q;

    // R2: one register stage between the pin and the mux
    p_sync_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sync_q == $past(raw_i));
endmodule

// File: rtl/mvf_chan_ctr.sv
module mvf_chan_ctr #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned CH_W   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [CH_W-1:0] ch_o
);
    localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

    logic [CH_W-1:0] ch_d, ch_q;

    always_comb begin
        ch_d = (ch_q == LAST) ? '0 : ch_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign ch_o = ch_q;

    // R1: strict round-robin stepping
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ch_q == (($past(ch_q) == LAST) ? '0 : $past(ch_q) + 1'b1));
    p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ch_q <= LAST);
endmodule

// File: rtl/mvf_hist_ram.sv
module mvf_hist_ram #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4,
    parameter int unsigned DW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[addr_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[addr_i];

    // R4: a write lands in the addressed entry
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
    // R3: without a write the addressed entry holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> mem_q[$past(addr_i)] == $past(rdata_o));
endmodule

// File: rtl/mvf_scan_filter.sv
module mvf_scan_filter
    import mvf_pkg::*;
#(
    parameter  int unsigned NUM_CH = 16,
    localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] rx_in,
    input  logic              sample_en,
    output logic [CH_W-1:0]   ch_out,
    output logic              filt_out
);
    typedef struct packed {
        logic [CH_W-1:0] ch;   // channel of the slot just taken
        logic            we;   // that slot was enabled
        logic            smp;  // inverted sample held for the channel
    } pipe_t;

    logic [NUM_CH-1:0] rx_sync;
    logic [CH_W-1:0]   ch_cur;
    logic [HIST_W-1:0] hist_rd, hist_wd;
    logic [2:0]        new3;
    pipe_t             pipe_d, pipe_q;

    mvf_sync #(.WIDTH(NUM_CH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (rx_in),
        .sync_o (rx_sync)
    );

    mvf_chan_ctr #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .ch_o  (ch_cur)
    );

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.ch  = ch_cur;
        pipe_d.we  = sample_en;
        if (sample_en) pipe_d.smp = ~rx_sync[ch_cur];
        new3       = {hist_rd[1:0], pipe_q.smp};
        hist_wd    = {vote3(new3), new3};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '{ch: '0, we: 1'b0, smp: 1'b0};
        else        pipe_q <= pipe_d;
    end

    mvf_hist_ram #(.DEPTH(NUM_CH), .AW(CH_W), .DW(HIST_W)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (pipe_q.we),
        .addr_i  (pipe_q.ch),
        .wdata_i (hist_wd),
        .rdata_o (hist_rd)
    );

    assign ch_out   = pipe_q.ch;
    assign filt_out = ~(pipe_q.we ? hist_wd[HIST_W-1] : hist_rd[HIST_W-1]);

    // R7: reported channel is the counter value one clock earlier
    p_chan_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ch_out == $past(ch_cur));
    // R3: an unsampled slot leaves the held sample alone
    p_smp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sample_en)) |-> $stable(pipe_q.smp));
    // R8: a single deviating sample cannot flip an output that the stored vote holds
    p_glitch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.we && hist_rd[1:0] == 2'b00) |-> filt_out);
endmodule

// File: tb/mvf_scan_filter_tb.sv
module mvf_scan_filter_tb;
    localparam int NCH = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] rx_in = '1;
    logic           sample_en = 1'b0;
    logic [3:0]     ch_out;
    logic           filt_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mvf_scan_filter #(.NUM_CH(NCH)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_in     (rx_in),
        .sample_en (sample_en),
        .ch_out    (ch_out),
        .filt_out  (filt_out)
    );

    // ---------------- scoreboard model (true-level samples) ----------------
    logic [2:0]     m_hist [NCH];
    logic [3:0]     m_ch, m_ch1;
    logic           m_we, m_smp;
    logic [NCH-1:0] m_sync;
    logic [4:0]     exp_q [$];

    function automatic logic maj(input logic [2:0] v);
        return ($countones(v) >= 2);
    endfunction

    always @(posedge clk) begin
        logic [2:0] v;
        if (!rst_n) begin
            m_ch = 0; m_ch1 = 0; m_we = 0; m_smp = 1; m_sync = '1;
            for (int i = 0; i < NCH; i++) m_hist[i] = 3'b111;
        end else begin
            if (m_we) m_hist[m_ch1] = {m_hist[m_ch1][1:0], m_smp};
            m_ch1 = m_ch;
            m_we  = sample_en;
            if (sample_en) m_smp = m_sync[m_ch];
            m_sync = rx_in;
            m_ch   = (m_ch == NCH - 1) ? 4'd0 : m_ch + 4'd1;
        end
        v = m_we ? {m_hist[m_ch1][1:0], m_smp} : m_hist[m_ch1];
        exp_q.push_back({m_ch1, maj(v)});
    end

    bit glitch_watch = 1'b0;

    always @(negedge clk) begin
        logic [4:0] e;
        if (!done && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (ch_out !== e[4:1]) begin
                failures++;
                $display("FAIL R1 R7 ch_out actual=%0d expected=%0d", ch_out, e[4:1]);
            end
            checks++;
            if (filt_out !== e[0]) begin
                failures++;
                $display("FAIL R2 R4 R5 filt_out ch=%0d actual=%0b expected=%0b",
                         e[4:1], filt_out, e[0]);
            end
            if (glitch_watch && ch_out == 4'd5) begin
                checks++;
                if (filt_out !== 1'b1) begin
                    failures++;
                    $display("FAIL R8 glitch reached output actual=%0b expected=1", filt_out);
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sample_chan(input int ch, input bit lvl, input bit exp, input string tag);
        @(negedge clk);
        rx_in[ch] = lvl;
        repeat (2) @(negedge clk);
        while (m_ch != ch) @(negedge clk);
        sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
        check(ch_out == 4'(ch) && filt_out == exp, tag, filt_out, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R6: reset state reads as mark on channel 0
        check(ch_out == 0, "R1 reset ch_out", ch_out, 0);
        check(filt_out == 1'b1, "R6 reset filt_out", filt_out, 1);
        rst_n = 1'b1;

        // R6: every channel idle after reset
        for (int k = 0; k < NCH; k++) begin
            @(negedge clk);
            check(filt_out == 1'b1, "R6 idle after reset", filt_out, 1);
        end

        // R8: single low sample on an idle line
        glitch_watch = 1'b1;
        sample_chan(5, 1, 1, "R8 pre-idle");
        sample_chan(5, 1, 1, "R8 pre-idle");
        sample_chan(5, 0, 1, "R8 glitch sample");
        sample_chan(5, 1, 1, "R8 after glitch");
        sample_chan(5, 1, 1, "R8 after glitch");
        glitch_watch = 1'b0;

        // R9: held low flips at second sample, held high flips back
        sample_chan(5, 0, 1, "R9 first low");
        sample_chan(5, 0, 0, "R9 second low");
        sample_chan(5, 0, 0, "R9 third low");
        sample_chan(5, 1, 0, "R9 first high");
        sample_chan(5, 1, 1, "R9 second high");

        // R5 R4: full vote table walk on channel 9 (newest sample last)
        sample_chan(9, 0, 1, "R5 pattern 110");
        sample_chan(9, 0, 0, "R5 pattern 100");
        sample_chan(9, 1, 0, "R5 pattern 001");
        sample_chan(9, 0, 0, "R5 pattern 010");
        sample_chan(9, 1, 1, "R5 pattern 101");
        sample_chan(9, 1, 1, "R5 pattern 011");
        sample_chan(9, 1, 1, "R5 pattern 111");
        sample_chan(9, 0, 1, "R4 shift 110");
        sample_chan(9, 0, 0, "R4 shift 100");
        sample_chan(9, 0, 0, "R5 pattern 000");

        // R3: line goes low but channel 2 is never enabled
        @(negedge clk);
        rx_in[2] = 1'b0;
        repeat (3 * NCH) @(negedge clk);
        while (ch_out != 4'd2) @(negedge clk);
        check(filt_out == 1'b1, "R3 unsampled channel held", filt_out, 1);
        rx_in[2] = 1'b1;

        // R2 R4 R5: random lines and strobes, scoreboard compares every cycle
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) rx_in = NCH'($urandom);
            sample_en = ($urandom_range(0, 2) != 0);
        end
        sample_en = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule